// File: doc/BRIEF.md
# 32-Pin GPIO Port Controller

This block is a general-purpose I/O port with one pad slice per pin, controlled through a simple word-addressed register bus. Software sets each pin's direction in two ways, and both views stay coherent. One way is a port-wide direction register, which also has write-one-to-set and write-one-to-clear aliases. The other is bit 0 of the pin's own configuration word. The configuration word also chooses whether the input buffer is connected and which pull, if any, is applied. Output levels are held in an output register, which also has set and clear aliases.

Each external pad input comes as two bits: a drive-valid bit and a level bit. When drive-valid is 0 the external source is floating. For every pin the block works out the level the pad settles at from the external drive, the pull choice, the pin's own output and the level it last held. It then presents that level in the input register, unless the buffer is disconnected. It drives a per-pin output level and output-enable. It raises a per-pin conflict flag when a pin drives while an external source drives the opposite level.

Word address map: 0x00 output, 0x01 output-set, 0x02 output-clear, 0x03 input, 0x04 direction, 0x05 direction-set, 0x06 direction-clear, and 0x40+n the configuration word of pin n. Configuration word layout: bit 0 direction (1 = output), bit 1 input-buffer disconnect (1 = disconnected), bits 3:2 pull (0b11 pull-up, 0b01 pull-down, other values no pull). Bits above 3 read as zero.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction and output registers read 0, every configuration word reads 0x2, the input register reads 0, and padOutEn and padOut are all zero.
- R2: Writing a mask to direction-set (0x05) sets those direction bits, and writing one to direction-clear (0x06) clears them. Bits whose mask bit is 0 keep their value. A write to 0x04 loads the direction register as a whole.
- R3: Bit 0 of each configuration word (0x40+n) always reads the same as direction bit n. Writing bit 0 of a configuration word changes direction bit n.
- R4: Output-set (0x01) and output-clear (0x02) set and clear the masked output bits, and a write to 0x00 loads the whole register. padOut follows the output register and padOutEn follows the direction register, both one cycle after the write.
- R5: When configuration bit 1 of a pin is 1, input register bit n reads 0 whatever the pad level.
- R6: On a floating input pin (padInValid=0), pull field 0b11 makes the input read 1 and 0b01 makes it read 0. When padInValid=1 the external level overrides the pull.
- R7: On an input pin with no pull and the buffer connected, a floating pad reads the level the pad last held.
- R8: An output pin with its buffer connected reads its own padOut level in the input register, even when an external source drives the opposite level.
- R9: conflict[n] is 1 exactly when pin n is an output, padInValid[n] is 1 and padIn[n] differs from padOut[n].
- R10: Read data appears on regRdData the cycle after the read strobe. Unmapped addresses, including 0x07 and configuration addresses past the last pin, read zero. regRdData is zero in any cycle not following a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Write strobe |
| regRdEn | input | 1 | Read strobe |
| regAddr | input | 8 | Word address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, one cycle after the read strobe |
| padIn | input | NUM_PINS | External drive level per pin |
| padInValid | input | NUM_PINS | 1 when an external source drives the pin, 0 when floating |
| padOut | output | NUM_PINS | Output level per pin |
| padOutEn | output | NUM_PINS | Output enable per pin |
| conflict | output | NUM_PINS | Pin drives against an opposite external level |

## Verification
Some behaviours are checked on every cycle. After a direction-set or direction-clear write, the masked output-enable bits take the new value and the unmasked bits hold. Output-clear empties padOut bits. A conflict never appears on a pin that is not driving or not externally driven. Read data stays zero unless a read strobe came before it. The bench scenarios are the only way to show how the input level is resolved: pull against external drive, hold on a floated pad, loopback and buffer disconnect. They also show the mirror between the configuration words and the direction register, because both depend on sequences of register traffic and pad stimulus.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_OUT      = 8'h00;
  localparam logic [ADDR_W-1:0] ADDR_OUTSET   = 8'h01;
  localparam logic [ADDR_W-1:0] ADDR_OUTCLR   = 8'h02;
  localparam logic [ADDR_W-1:0] ADDR_IN       = 8'h03;
  localparam logic [ADDR_W-1:0] ADDR_DIR      = 8'h04;
  localparam logic [ADDR_W-1:0] ADDR_DIRSET   = 8'h05;
  localparam logic [ADDR_W-1:0] ADDR_DIRCLR   = 8'h06;
  localparam logic [ADDR_W-1:0] ADDR_CFG_BASE = 8'h40;

  localparam logic [1:0] PULL_UP   = 2'b11;
  localparam logic [1:0] PULL_DOWN = 2'b01;

  typedef enum logic [2:0] {
    RD_NONE, RD_OUT, RD_IN, RD_DIR, RD_CFG
  } rdSel_e;

  typedef struct packed {
    logic              outWr;
    logic              outSet;
    logic              outClr;
    logic              dirWr;
    logic              dirSet;
    logic              dirClr;
    logic              cfgWr;
    rdSel_e            rdSel;
    logic [ADDR_W-1:0] cfgIdx;
  } strobe_t;
endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           strobe
);
  localparam int unsigned CFG_END = int'(ADDR_CFG_BASE) + NUM_PINS;

  logic cfgHit;

  always_comb begin
    cfgHit = (int'(regAddr) >= int'(ADDR_CFG_BASE)) && (int'(regAddr) < CFG_END);
    strobe        = '0;
    strobe.rdSel  = RD_NONE;
    strobe.cfgIdx = regAddr - ADDR_CFG_BASE;
    if (regWrEn) begin
      strobe.outWr  = (regAddr == ADDR_OUT);
      strobe.outSet = (regAddr == ADDR_OUTSET);
      strobe.outClr = (regAddr == ADDR_OUTCLR);
      strobe.dirWr  = (regAddr == ADDR_DIR);
      strobe.dirSet = (regAddr == ADDR_DIRSET);
      strobe.dirClr = (regAddr == ADDR_DIRCLR);
      strobe.cfgWr  = cfgHit;
    end
    if (regRdEn) begin
      if (regAddr == ADDR_OUT || regAddr == ADDR_OUTSET || regAddr == ADDR_OUTCLR)
        strobe.rdSel = RD_OUT;
      else if (regAddr == ADDR_IN)
        strobe.rdSel = RD_IN;
      else if (regAddr == ADDR_DIR || regAddr == ADDR_DIRSET || regAddr == ADDR_DIRCLR)
        strobe.rdSel = RD_DIR;
      else if (cfgHit)
        strobe.rdSel = RD_CFG;
    end
  end
endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobe,
  input  logic [REG_W-1:0]    regWrData,
  output logic [REG_W-1:0]    regRdData,
  input  logic [NUM_PINS-1:0] padIn,
  input  logic [NUM_PINS-1:0] padInValid,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOutEn,
  output logic [NUM_PINS-1:0] conflict
);
  localparam int unsigned IDX_W = $clog2(NUM_PINS);

  logic [NUM_PINS-1:0] outReg, dirReg, discReg, lastLevel;
  logic [NUM_PINS-1:0] padLevel, inVec, wMask;
  logic [1:0]          pullReg [NUM_PINS];
  logic [IDX_W-1:0]    idx;

  assign wMask = regWrData[NUM_PINS-1:0];
  assign idx   = strobe.cfgIdx[IDX_W-1:0];

  // Pad resolution per pin: own drive, then external, then pull, then hold.
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    always_comb begin
      if (dirReg[p])
        padLevel[p] = outReg[p];
      else if (padInValid[p])
        padLevel[p] = padIn[p];
      else if (pullReg[p] == PULL_UP)
        padLevel[p] = 1'b1;
      else if (pullReg[p] == PULL_DOWN)
        padLevel[p] = 1'b0;
      else
        padLevel[p] = lastLevel[p];
    end
    assign inVec[p]    = padLevel[p] & ~discReg[p];
    assign conflict[p] = dirReg[p] & padInValid[p] & (padIn[p] ^ outReg[p]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outReg    <= '0;
      dirReg    <= '0;
      discReg   <= '1;
      lastLevel <= '0;
      for (int p = 0; p < NUM_PINS; p++) pullReg[p] <= 2'b00;
    end else begin
      lastLevel <= padLevel;
      if (strobe.outWr)  outReg <= wMask;
      if (strobe.outSet) outReg <= outReg | wMask;
      if (strobe.outClr) outReg <= outReg & ~wMask;
      if (strobe.dirWr)  dirReg <= wMask;
      if (strobe.dirSet) dirReg <= dirReg | wMask;
      if (strobe.dirClr) dirReg <= dirReg & ~wMask;
      if (strobe.cfgWr) begin
        dirReg[idx]  <= regWrData[0];
        discReg[idx] <= regWrData[1];
        pullReg[idx] <= regWrData[3:2];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRdData <= '0;
    end else begin
      unique case (strobe.rdSel)
        RD_OUT:  regRdData <= REG_W'(outReg);
        RD_IN:   regRdData <= REG_W'(inVec);
        RD_DIR:  regRdData <= REG_W'(dirReg);
        RD_CFG:  regRdData <= REG_W'({pullReg[idx], discReg[idx], dirReg[idx]});
        default: regRdData <= '0;
      endcase
    end
  end

  assign padOut   = outReg;
  assign padOutEn = dirReg;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic                regRdEn,
  input  logic [7:0]          regAddr,
  input  logic [31:0]         regWrData,
  output logic [31:0]         regRdData,
  input  logic [NUM_PINS-1:0] padIn,
  input  logic [NUM_PINS-1:0] padInValid,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOutEn,
  output logic [NUM_PINS-1:0] conflict
);
  strobe_t strobe;

  gpio_port_ctrl #(.NUM_PINS(NUM_PINS)) u_ctrl (
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .strobe  (strobe)
  );

  gpio_port_dp #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .padIn      (padIn),
    .padInValid (padInValid),
    .padOut     (padOut),
    .padOutEn   (padOutEn),
    .conflict   (conflict)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                regWrEn,
  input logic                regRdEn,
  input logic [7:0]          regAddr,
  input logic [31:0]         regWrData,
  input logic [31:0]         regRdData,
  input logic [NUM_PINS-1:0] padInValid,
  input logic [NUM_PINS-1:0] padOut,
  input logic [NUM_PINS-1:0] padOutEn,
  input logic [NUM_PINS-1:0] conflict
);
  logic [NUM_PINS-1:0] mask;
  assign mask = regWrData[NUM_PINS-1:0];

  a_r1_reset_idle: assert property (@(posedge clk)
    $rose(rstN) |-> (padOutEn == '0 && padOut == '0));

  a_r2_dirset_sets: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_DIRSET) |=> ((padOutEn & $past(mask)) == $past(mask)));

  a_r2_dirset_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_DIRSET) |=> ((padOutEn & ~$past(mask)) == ($past(padOutEn) & ~$past(mask))));

  a_r2_dirclr_clears: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_DIRCLR) |=> ((padOutEn & $past(mask)) == '0));

  a_r4_outclr_clears: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_OUTCLR) |=> ((padOut & $past(mask)) == '0));

  a_r9_conflict_needs_drive: assert property (@(posedge clk) disable iff (!rstN)
    ((conflict & ~(padOutEn & padInValid)) == '0));

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !regRdEn |=> (regRdData == '0));

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == 8'h07) |=> (regRdData == '0));
endmodule

bind gpio_port gpio_port_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regWrEn    (regWrEn),
  .regRdEn    (regRdEn),
  .regAddr    (regAddr),
  .regWrData  (regWrData),
  .regRdData  (regRdData),
  .padInValid (padInValid),
  .padOut     (padOut),
  .padOutEn   (padOutEn),
  .conflict   (conflict)
);

// File: tb/gpio_port_bench.sv
module gpio_port_bench;
  localparam int unsigned N = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [N-1:0] padIn = '0, padInValid = '0;
  logic [N-1:0] padOut, padOutEn, conflict;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_port #(.NUM_PINS(N)) u_gpio_port (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .padIn(padIn), .padInValid(padInValid), .padOut(padOut),
    .padOutEn(padOutEn), .conflict(conflict)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  // Expected input bit for a pin whose level never depends on history.
  function automatic logic expIn(input logic [3:0] cfg, input logic o,
                                 input logic ext, input logic vld);
    logic lvl;
    if (cfg[0])                lvl = o;
    else if (vld)              lvl = ext;
    else if (cfg[3:2] == 2'b11) lvl = 1'b1;
    else                       lvl = 1'b0;
    return lvl & ~cfg[1];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] mDir, mOut;
    logic [3:0]  cfgs [N];
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check("R1 padOutEn", padOutEn, '0);
    check("R1 padOut", padOut, '0);
    busRead(8'h04, rd); check("R1 dir", rd, 0);
    busRead(8'h00, rd); check("R1 out", rd, 0);
    busRead(8'h03, rd); check("R1 in", rd, 0);
    for (int i = 0; i < N; i++) begin
      busRead(8'h40 + 8'(i), rd); check("R1 cfg", rd, 32'h2);
    end

    // R10 unmapped and idle
    busRead(8'h07, rd); check("R10 unmapped 07", rd, 0);
    busRead(8'h40 + 8'(N), rd); check("R10 past last cfg", rd, 0);
    busRead(8'h04, rd);
    @(negedge clk); check("R10 idle zero", regRdData, 0);

    // R2 / R3 direction views
    busWrite(8'h05, 32'h8000_0001);
    busRead(8'h04, rd); check("R2 dirset", rd, 32'h8000_0001);
    busRead(8'h40, rd); check("R3 cfg0 mirror", rd[0], 1);
    busRead(8'h40 + 8'(N-1), rd); check("R3 cfg last mirror", rd[0], 1);
    busWrite(8'h05, 32'h0000_0100);
    busRead(8'h04, rd); check("R2 dirset keeps others", rd, 32'h8000_0101);
    busWrite(8'h06, 32'h8000_0001);
    busRead(8'h04, rd); check("R2 dirclr", rd, 32'h0000_0100);
    busRead(8'h40, rd); check("R3 cfg0 cleared", rd, 32'h2);
    busWrite(8'h04, 32'h0);
    busWrite(8'h45, 32'h3);
    busRead(8'h04, rd); check("R3 cfg write sets dir", rd, 32'h20);
    busWrite(8'h45, 32'h2);
    busRead(8'h04, rd); check("R3 cfg write clears dir", rd, 32'h0);

    // R7 hold on floating pad, no pull
    busWrite(8'h40, 32'h0);
    padInValid[0] = 1'b1; padIn[0] = 1'b0;
    busRead(8'h03, rd); check("R7 driven low", rd[0], 0);
    padIn[0] = 1'b1;
    busRead(8'h03, rd); check("R7 driven high", rd[0], 1);
    padInValid[0] = 1'b0; padIn[0] = 1'b0;
    busRead(8'h03, rd); check("R7 float holds high", rd[0], 1);
    repeat (3) @(negedge clk);
    busRead(8'h03, rd); check("R7 still holds", rd[0], 1);
    padInValid[0] = 1'b1;
    busRead(8'h03, rd);
    padInValid[0] = 1'b0;
    busRead(8'h03, rd); check("R7 float holds low", rd[0], 0);

    // R6 pulls
    busWrite(8'h40, 32'hC);
    busRead(8'h03, rd); check("R6 pull-up float", rd[0], 1);
    busWrite(8'h40, 32'h4);
    busRead(8'h03, rd); check("R6 pull-down float", rd[0], 0);
    padInValid[0] = 1'b1; padIn[0] = 1'b1;
    busRead(8'h03, rd); check("R6 drive overrides pull-down", rd[0], 1);
    busWrite(8'h40, 32'hC); padIn[0] = 1'b0;
    busRead(8'h03, rd); check("R6 drive overrides pull-up", rd[0], 0);

    // R5 disconnected buffer
    busWrite(8'h40, 32'hE); padIn[0] = 1'b1;
    busRead(8'h03, rd); check("R5 disconnected", rd[0], 0);
    padInValid[0] = 1'b0;

    // R4 outputs
    busWrite(8'h40, 32'h3);
    busWrite(8'h01, 32'h1);
    check("R4 padOut set", padOut[0], 1);
    check("R4 padOutEn", padOutEn[0], 1);
    busWrite(8'h02, 32'h1);
    check("R4 padOut clr", padOut[0], 0);

    // R8 loopback, R9 conflict
    busWrite(8'h40, 32'h1);
    busWrite(8'h01, 32'h1);
    busRead(8'h03, rd); check("R8 loopback high", rd[0], 1);
    padInValid[0] = 1'b1; padIn[0] = 1'b0;
    #1 check("R9 conflict", conflict[0], 1);
    busRead(8'h03, rd); check("R8 own level wins", rd[0], 1);
    padIn[0] = 1'b1;
    #1 check("R9 same level no conflict", conflict[0], 0);
    padInValid[0] = 1'b0;
    #1 check("R9 float no conflict", conflict[0], 0);
    busWrite(8'h02, 32'h1);
    busRead(8'h03, rd); check("R8 loopback low", rd[0], 0);
    busWrite(8'h40, 32'h2);

    // R2 / R4 random register traffic
    busWrite(8'h04, 0); busWrite(8'h00, 0);
    mDir = 0; mOut = 0;
    for (int it = 0; it < 200; it++) begin
      logic [31:0] d;
      int op;
      d = $urandom; op = $urandom_range(0, 5);
      case (op)
        0: begin busWrite(8'h04, d); mDir = d; end
        1: begin busWrite(8'h05, d); mDir |= d; end
        2: begin busWrite(8'h06, d); mDir &= ~d; end
        3: begin busWrite(8'h00, d); mOut = d; end
        4: begin busWrite(8'h01, d); mOut |= d; end
        default: begin busWrite(8'h02, d); mOut &= ~d; end
      endcase
      check("R2 padOutEn model", padOutEn, mDir);
      check("R4 padOut model", padOut, mOut);
    end
    busRead(8'h04, rd); check("R2 dir read model", rd, mDir);
    busRead(8'h00, rd); check("R4 out read model", rd, mOut);

    // R5/R6/R8/R9 random pin configurations
    for (int it = 0; it < 30; it++) begin
      logic [31:0] expV, expC;
      logic [N-1:0] ext, vld;
      ext = $urandom; vld = $urandom; mOut = $urandom;
      for (int p = 0; p < N; p++) begin
        cfgs[p] = 4'($urandom);
        if (!cfgs[p][0] && cfgs[p][3:2] != 2'b11 && cfgs[p][3:2] != 2'b01)
          vld[p] = 1'b1;
        busWrite(8'h40 + 8'(p), 32'(cfgs[p]));
      end
      busWrite(8'h00, mOut);
      padIn = ext; padInValid = vld;
      expV = 0; expC = 0;
      for (int p = 0; p < N; p++) begin
        expV[p] = expIn(cfgs[p], mOut[p], ext[p], vld[p]);
        expC[p] = cfgs[p][0] & vld[p] & (ext[p] ^ mOut[p]);
      end
      busRead(8'h03, rd); check("R6 R8 R5 in model", rd, expV);
      check("R9 conflict model", conflict, expC);
      busRead(8'h40 + 8'(it % N), rd);
      check("R3 cfg readback", rd, 32'(cfgs[it % N]));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule